// File: doc/BRIEF.md
# Sampling Converter Sequencer with Control Word

This block is the digital core of an eight-channel, twelve-bit sampling converter. A host loads a six-bit control word through a parallel write port with chip select and write strobe. The word picks the channel, the output coding, a software standby request and a software start request. A conversion can begin in two ways. One is a rising edge on the hardware start pin. The other is a control write that carries the start bit.

A cycle counter times each conversion. On the final conversion cycle the block captures a twelve-bit value from a port that stands in for the analog path. It then drops an active-low end-of-conversion strobe for a fixed number of cycles. After the strobe, an acquisition window must expire before the next start is taken. The host reads the captured value while chip select and read strobe are both low. The value comes out either as straight binary or with its top bit inverted (two's complement).

Standby can come from a pin or from the control word. Either source returns the sequencer to idle and keeps the strobe quiet.

Top module: `adc_seq_core`

States:
- `ST_IDLE`: waiting for a start.
- `ST_CONV`: conversion timing, lasting `CONV_CYC` cycles.
- `ST_EOC`: strobe low, lasting `EOC_CYC` cycles.
- `ST_ACQ`: acquisition window, lasting `ACQ_CYC` cycles.

Transitions:
- idle to conv: on a start request.
- conv to eoc: when the counter reaches zero; the sample is captured on this edge.
- eoc to acq: when the counter expires.
- acq to idle: when the counter expires.
- any state to idle: while standby is active.

## Requirements
- R1: After reset, `eoc_n` is 1, `rd_oe` is 0, `rd_data` is 0 and `chan_sel` is 0. The control word resets to all zeros.
- R2: A write is accepted on the first clock edge at which `cs_n` and `wr_n` are both low. Further edges while the strobe stays low are not new writes. The control word fields are:
  - bit 0: output format.
  - bit 1: software standby.
  - bit 2: software start.
  - bits 5..3: channel number, driven on `chan_sel` after the edge that accepts the write.
- R3: A rising edge on `convst` is detected on the first clock edge at which `convst` is sampled high. `eoc_n` goes low on the `CONV_CYC`-th clock edge after that edge.
- R4: A write with bit 2 set starts a conversion. `eoc_n` goes low on the (`CONV_CYC`+1)-th edge after the edge that accepts the write.
- R5: Each end-of-conversion strobe holds `eoc_n` low for exactly `EOC_CYC` clock cycles.
- R6: The result is the value of `sample_in` at the edge that ends the conversion. Format is applied at read time from the current bit 0:
  - bit 0 = 0: the result is read unchanged.
  - bit 0 = 1: the result is read with bit 11 inverted.
- R7: While `cs_n` and `rd_n` are both low, `rd_oe` is 1 and `rd_data` carries the formatted result. Otherwise `rd_oe` is 0 and `rd_data` is 0.
- R8: Start requests from either source are ignored in three places: during a conversion, during the strobe, and during the `ACQ_CYC`-cycle acquisition window after it. An ignored request produces no extra strobe.
- R9: While `standby_n` is low or control bit 1 is set, the sequencer returns to idle. In that time no strobe appears and starts are ignored. After standby is released, a new start converts normally.
- R10: `chan_sel` changes only as the result of an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ctrl_in | input | 6 | Control word written on an accepted write |
| convst | input | 1 | Hardware start, rising-edge active |
| standby_n | input | 1 | Standby pin, low forces standby |
| sample_in | input | 12 | Converted value from the analog path |
| chan_sel | output | 3 | Channel number to the input multiplexer |
| eoc_n | output | 1 | End-of-conversion strobe, active low |
| rd_data | output | 12 | Read data to the bus pad |
| rd_oe | output | 1 | Bus drive enable for the pad |

## Verification
The assertions check four behaviours on every cycle:
- The strobe is never shorter than two cycles.
- At least one idle cycle follows each strobe.
- The strobe stays silent through sustained standby.
- The bus is released outside a read, and the channel output holds between writes.

Only the bench scenarios can show the rest:
- The exact start-to-strobe latency for each start source.
- Which sample value is captured.
- The coding applied at read time.
- That starts during a conversion or an acquisition window produce no second strobe.
- That conversion resumes cleanly after each kind of standby.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CTRL_W = 6;
    localparam int CH_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONV,
        ST_EOC,
        ST_ACQ
    } seq_state_t;

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            start;
        logic            stby;
        logic            fmt;
    } ctrl_word_t;

endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [CH_W-1:0]   chan,
    output logic              stby_bit,
    output logic              fmt_bit,
    output logic              soft_go
);
    ctrl_word_t word_in;
    logic       wr_act;
    logic       wr_act_q;
    logic       accept;

    assign word_in = ctrl_word_t'(ctrl_in);
    assign wr_act  = ~cs_n & ~wr_n;
    assign accept  = wr_act & ~wr_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            chan     <= '0;
            stby_bit <= 1'b0;
            fmt_bit  <= 1'b0;
            soft_go  <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
            soft_go  <= accept & word_in.start;
            if (accept) begin
                chan     <= word_in.chan;
                stby_bit <= word_in.stby;
                fmt_bit  <= word_in.fmt;
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DW       = 12,
    parameter int CONV_CYC = 200,
    parameter int EOC_CYC  = 10,
    parameter int ACQ_CYC  = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stby,
    input  logic [DW-1:0] sample_in,
    output logic          eoc_n,
    output logic [DW-1:0] result
);
    localparam int MAXC = (CONV_CYC > ACQ_CYC) ?
                          ((CONV_CYC > EOC_CYC) ? CONV_CYC : EOC_CYC) :
                          ((ACQ_CYC > EOC_CYC) ? ACQ_CYC : EOC_CYC);
    localparam int CW = $clog2(MAXC + 1);

    seq_state_t    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            result <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (cap) result <= sample_in;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = (cnt != '0) ? cnt - 1'b1 : cnt;
        cap     = 1'b0;
        if (stby) begin
            nxt     = ST_IDLE;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    nxt     = ST_CONV;
                    cnt_nxt = CW'(CONV_CYC - 1);
                end
                ST_CONV: if (cnt == '0) begin
                    nxt     = ST_EOC;
                    cnt_nxt = CW'(EOC_CYC - 1);
                    cap     = 1'b1;
                end
                ST_EOC: if (cnt == '0) begin
                    nxt     = ST_ACQ;
                    cnt_nxt = CW'(ACQ_CYC - 1);
                end
                ST_ACQ: if (cnt == '0) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eoc_n = (state != ST_EOC);
    end
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
    import adc_seq_pkg::*;
#(
    parameter int DW       = 12,
    parameter int CONV_CYC = 200,
    parameter int EOC_CYC  = 10,
    parameter int ACQ_CYC  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              convst,
    input  logic              standby_n,
    input  logic [DW-1:0]     sample_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic              eoc_n,
    output logic [DW-1:0]     rd_data,
    output logic              rd_oe
);
    localparam int MSB = DW - 1;

    logic          stby_bit, fmt_bit, soft_go, hw_go;
    logic [DW-1:0] result, coded;

    adc_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
        .ctrl_in(ctrl_in), .chan(chan_sel), .stby_bit(stby_bit),
        .fmt_bit(fmt_bit), .soft_go(soft_go)
    );

    adc_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(convst), .rise(hw_go)
    );

    adc_seq_fsm #(
        .DW(DW), .CONV_CYC(CONV_CYC), .EOC_CYC(EOC_CYC), .ACQ_CYC(ACQ_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(hw_go | soft_go),
        .stby(~standby_n | stby_bit), .sample_in(sample_in),
        .eoc_n(eoc_n), .result(result)
    );

    assign coded   = fmt_bit ? {~result[MSB], result[MSB-1:0]} : result;
    assign rd_oe   = ~cs_n & ~rd_n;
    assign rd_data = rd_oe ? coded : '0;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        wr_n,
    input logic        rd_n,
    input logic        standby_n,
    input logic [2:0]  chan_sel,
    input logic        eoc_n,
    input logic [11:0] rd_data,
    input logic        rd_oe
);
    a_r5_eoc_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |=> !eoc_n);

    a_r8_gap_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_n) |=> eoc_n);

    a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_n && $past(!standby_n)) |-> eoc_n);

    a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!rd_oe && rd_data == 12'd0));

    a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(rst_n)) |-> $stable(chan_sel));

    logic unused_wr;
    assign unused_wr = wr_n;
endmodule

bind adc_seq_core adc_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .standby_n(standby_n), .chan_sel(chan_sel), .eoc_n(eoc_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
);

// File: tb/adc_seq_core_test.sv
module adc_seq_core_test;
    localparam int CONV = 200;
    localparam int EOCW = 10;
    localparam int ACQ  = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [5:0]  ctrl_in = '0;
    logic        convst = 1'b0, standby_n = 1'b1;
    logic [11:0] sample_in = '0;
    logic [2:0]  chan_sel;
    logic        eoc_n;
    logic [11:0] rd_data;
    logic        rd_oe;

    int checks = 0, errors = 0, cyc = 0, eoc_events = 0;
    int exp_q[$];
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_seq_core #(.CONV_CYC(CONV), .EOC_CYC(EOCW), .ACQ_CYC(ACQ)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .ctrl_in(ctrl_in), .convst(convst), .standby_n(standby_n),
        .sample_in(sample_in), .chan_sel(chan_sel), .eoc_n(eoc_n),
        .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: strobe timing against the scoreboard queue (R3, R4, R5, R8, R9)
    initial begin
        bit prev = 1'b1;
        int width = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev && !eoc_n) begin
                    eoc_events++;
                    if (exp_q.size() == 0) begin
                        chk("R8/R9 unexpected strobe", cyc, -1);
                    end else begin
                        chk("R3/R4 strobe cycle", cyc, exp_q.pop_front());
                    end
                    width = 1;
                end else if (!eoc_n) begin
                    width++;
                end else if (!prev) begin
                    chk("R5 strobe width", width, EOCW);
                end
                prev = eoc_n;
            end
        end
    end

    task automatic write_ctrl(input logic [5:0] w, input bit expect_start);
        @(negedge clk);
        cs_n = 0; wr_n = 0; ctrl_in = w;
        if (expect_start) exp_q.push_back(cyc + 2 + CONV);
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic hw_start(input bit expect_start);
        @(negedge clk);
        convst = 1;
        if (expect_start) exp_q.push_back(cyc + 1 + CONV);
        repeat (5) @(negedge clk);
        convst = 0;
    endtask

    task automatic wait_done();
        wait (exp_q.size() == 0);
        repeat (EOCW + ACQ + 4) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input int exp);
        @(negedge clk);
        cs_n = 0; rd_n = 0;
        #1;
        chk({req, " oe"}, int'(rd_oe), 1);
        chk(req, int'(rd_data), exp);
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        #1;
        chk("R7 released oe", int'(rd_oe), 0);
        chk("R7 released data", int'(rd_data), 0);
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog", 1, 0);
        report();
    end

    initial begin
        int ev;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 eoc_n", int'(eoc_n), 1);
        chk("R1 rd_oe", int'(rd_oe), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 chan_sel", int'(chan_sel), 0);
        rst_n = 1;

        // R2 channel field, format 0
        write_ctrl(6'b101_000, 0);
        @(negedge clk);
        chk("R2 chan_sel", int'(chan_sel), 5);

        // R3/R6 hardware start, sample changes mid-conversion
        sample_in = 12'h111;
        hw_start(1);
        repeat (50) @(negedge clk);
        sample_in = 12'hA53;
        wait_done();
        sample_in = 12'h000;
        read_chk("R6 straight binary", 12'hA53);

        // R6 format switched at read time
        write_ctrl(6'b101_001, 0);
        read_chk("R6 twos complement", 12'h253);

        // R4 software start, channel 2, format 1
        sample_in = 12'h07F;
        write_ctrl(6'b010_101, 1);
        @(negedge clk);
        chk("R2 chan after soft start", int'(chan_sel), 2);
        wait_done();
        read_chk("R4/R6 soft result", 12'h87F);

        // R8 starts during conversion and acquisition ignored
        ev = eoc_events;
        sample_in = 12'h3C0;
        hw_start(1);
        repeat (20) @(negedge clk);
        hw_start(0);
        write_ctrl(6'b010_100, 0);
        wait (eoc_n == 0);
        repeat (EOCW + 3) @(negedge clk);
        hw_start(0);
        repeat (CONV + ACQ) @(negedge clk);
        chk("R8 single strobe", eoc_events - ev, 1);
        read_chk("R8 result", 12'h3C0);

        // R9 standby pin aborts and blocks starts
        ev = eoc_events;
        hw_start(0);
        repeat (30) @(negedge clk);
        standby_n = 0;
        hw_start(0);
        repeat (CONV + EOCW + 10) @(negedge clk);
        chk("R9 pin standby no strobe", eoc_events - ev, 0);
        standby_n = 1;
        sample_in = 12'h5A5;
        hw_start(1);
        wait_done();
        read_chk("R9 after pin standby", 12'h5A5);

        // R9 standby control bit
        ev = eoc_events;
        write_ctrl(6'b010_010, 0);
        hw_start(0);
        write_ctrl(6'b010_110, 0);
        repeat (CONV + EOCW + 10) @(negedge clk);
        chk("R9 bit standby no strobe", eoc_events - ev, 0);
        write_ctrl(6'b011_000, 0);
        sample_in = 12'hFFF;
        hw_start(1);
        wait_done();
        read_chk("R9 after bit standby", 12'hFFF);

        // R10 channel holds without writes
        repeat (20) @(negedge clk);
        chk("R10 chan held", int'(chan_sel), 3);

        report();
    end
endmodule